// File: doc/BRIEF.md
# Regulator Power Sequencing Controller

This block drives the enables of four voltage regulators from a single master enable line. Rails 0 and 1 are the two buck converters and rails 2 and 3 are the two low-dropout regulators. The master line is synchronised and then filtered, so a level is accepted only after it has stayed unchanged for a programmable settle time. A rising edge of the filtered level starts a timed power-on walk through the rails in the order 0 to 3. A falling edge starts a timed shutdown walk in the order 3 to 0. The rail that a step switches selects that step's delay, which comes from a menu of six values. The timebase is a 0.5 ms tick made by a clock prescaler, so every delay is a whole number of ticks.

Each rail output is the AND of a configuration enable bit with the OR of that rail's external enable pin and the sequenced enable. The configuration is a small register set loaded by a single write strobe. Configuration reset leaves every rail enabled and sets the step delays to 1.5, 2, 3 and 6 ms. If the master edge reverses while a walk is running, the walk is dropped and the opposite walk starts from the rails that are on at that moment. The block shows a busy level while a walk is in progress and a one-cycle done pulse when a walk ends.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After synchronous reset, all four configuration enable bits are 1 and the delay codes for rails 0..3 are 1, 2, 3 and 4. No rail is sequenced on, busy is low and done is low.
- R2: Each output follows `rail_on_o[i] = en[i] & (ext[i] | seq[i])`. Here `ext` is the pin after a two-stage synchroniser, and the output is registered.
- R3: A new master level is accepted only after it has been stable for FILT_HALF_MS × HALF_MS_CYCLES cycles (1 ms by default). Shorter pulses do not change any output.
- R4: On an accepted rising edge, rails are sequenced on in the order 0, 1, 2, 3. Rail k turns on exactly ticks(code[k]) × HALF_MS_CYCLES cycles after rail k-1 turns on.
- R5: Delay code to ticks of 0.5 ms: 0→2, 1→3, 2→4, 3→6, 4→12, 5→22. Codes 6 and 7 also give 22.
- R6: On an accepted falling edge, rails are sequenced off in the order 3, 2, 1, 0. Rail k turns off exactly ticks(code[k]) × HALF_MS_CYCLES cycles after rail k+1 turns off.
- R7: When power-on has completed and every enable bit is set, toggling the external pins leaves all outputs high.
- R8: Busy is high while a walk is in progress. Done pulses high for exactly one cycle when a walk completes, once per completed walk.
- R9: An opposite master edge during a walk abandons that walk. The new walk starts from the rails that are on, and rails not yet reached stay off.
- R10: A cycle with `cfg_wr_i` high loads `cfg_rail_en_i` and `cfg_dly_i`. The delay code for rail k sits at bits [3k+2:3k]. The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| master_en_i | input | 1 | Asynchronous master enable line |
| ext_en_i | input | 4 | Asynchronous per-rail external enable pins |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rail_en_i | input | 4 | Per-rail enable bits to load |
| cfg_dly_i | input | 12 | Per-rail 3-bit delay codes to load |
| rail_on_o | output | 4 | Regulator enable outputs |
| seq_busy_o | output | 1 | Sequence in progress |
| seq_done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A wrong internal state shows up at the ports as a rail that switches out of order or a step interval that is off by whole clock cycles. The bench times every rail transition to the exact cycle, so a prescaler or tick-count error appears at the first step it affects, within one delay period. A filter count that is too short lets a sub-threshold pulse start a sequence, and this shows as a rail turning on within a few hundred cycles. A corrupted step level or direction shows as a rail that comes on when it should have stayed off after a reversal. An extra or missing done pulse is visible in the count of pulses per walk.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
    localparam int NUM_RAILS = 4;
    localparam int CODE_W    = 3;
    localparam int TICK_W    = 5;
    localparam int IDX_W     = $clog2(NUM_RAILS);
    localparam int LVL_W     = $clog2(NUM_RAILS + 1);

    typedef logic [CODE_W-1:0] dly_code_t;
    typedef logic [TICK_W-1:0] tick_cnt_t;

    typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} walk_dir_e;

    typedef struct packed {
        logic [NUM_RAILS-1:0]        en;
        dly_code_t [NUM_RAILS-1:0]   dly;
    } rail_cfg_t;

    typedef struct packed {
        walk_dir_e         dir;
        logic              busy;
        logic [LVL_W-1:0]  level;
    } walk_state_t;

    localparam dly_code_t [NUM_RAILS-1:0] DEFAULT_CODES =
        {3'd4, 3'd3, 3'd2, 3'd1};

    function automatic tick_cnt_t ticks_of(input dly_code_t code);
        tick_cnt_t t;
        case (code)
            3'd0:    t = 5'd2;
            3'd1:    t = 5'd3;
            3'd2:    t = 5'd4;
            3'd3:    t = 5'd6;
            3'd4:    t = 5'd12;
            default: t = 5'd22;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/pseq_deglitch.sv
module pseq_deglitch #(
    parameter int STABLE_CYCLES = 100000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    logic             sync_q1, sync_q2, level_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q1 <= 1'b0;
            sync_q2 <= 1'b0;
            level_q <= 1'b0;
            cnt_q   <= '0;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            sync_q1 <= raw_i;
            sync_q2 <= sync_q1;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
            if (sync_q2 == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(STABLE_CYCLES - 1)) begin
                cnt_q   <= '0;
                level_q <= sync_q2;
                rise_o  <= sync_q2;
                fall_o  <= ~sync_q2;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pseq_step_timer.sv
module pseq_step_timer
    import pseq_pkg::*;
#(
    parameter int HALF_MS_CYCLES = 50000
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      load_i,
    input  logic      stop_i,
    input  tick_cnt_t ticks_i,
    output logic      expire_o
);
    localparam int PRE_W = $clog2(HALF_MS_CYCLES + 1);

    logic [PRE_W-1:0] pre_q;
    tick_cnt_t        tcnt_q, target_q;
    logic             run_q;
    logic             tick_end;

    assign tick_end = (pre_q == PRE_W'(HALF_MS_CYCLES - 1));
    assign expire_o = run_q && tick_end && (tcnt_q == target_q - 1'b1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_q    <= '0;
            tcnt_q   <= '0;
            target_q <= '0;
            run_q    <= 1'b0;
        end else if (load_i) begin
            pre_q    <= '0;
            tcnt_q   <= '0;
            target_q <= ticks_i;
            run_q    <= 1'b1;
        end else if (stop_i || expire_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (tick_end) begin
                pre_q  <= '0;
                tcnt_q <= tcnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pseq_walker.sv
module pseq_walker
    import pseq_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        rise_i,
    input  logic                        fall_i,
    input  logic                        expire_i,
    input  dly_code_t [NUM_RAILS-1:0]   codes_i,
    output logic                        load_o,
    output logic                        stop_o,
    output tick_cnt_t                   ticks_o,
    output logic [NUM_RAILS-1:0]        mask_o,
    output logic                        busy_o,
    output logic                        done_o
);
    walk_state_t      st_q, st_d;
    logic             done_d;
    logic [IDX_W-1:0] idx;

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        load_o = 1'b0;
        stop_o = 1'b0;
        idx    = '0;
        if (rise_i) begin
            st_d.dir = DIR_UP;
            if (st_q.level == LVL_W'(NUM_RAILS)) begin
                st_d.busy = 1'b0;
                done_d    = 1'b1;
                stop_o    = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                load_o    = 1'b1;
                idx       = IDX_W'(st_q.level);
            end
        end else if (fall_i) begin
            st_d.dir = DIR_DOWN;
            if (st_q.level == '0) begin
                st_d.busy = 1'b0;
                done_d    = 1'b1;
                stop_o    = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                load_o    = 1'b1;
                idx       = IDX_W'(st_q.level - 1'b1);
            end
        end else if (st_q.busy && expire_i) begin
            if (st_q.dir == DIR_UP) begin
                st_d.level = st_q.level + 1'b1;
                if (st_q.level == LVL_W'(NUM_RAILS - 1)) begin
                    st_d.busy = 1'b0;
                    done_d    = 1'b1;
                end else begin
                    load_o = 1'b1;
                    idx    = IDX_W'(st_q.level + 1'b1);
                end
            end else begin
                st_d.level = st_q.level - 1'b1;
                if (st_q.level == LVL_W'(1)) begin
                    st_d.busy = 1'b0;
                    done_d    = 1'b1;
                end else begin
                    load_o = 1'b1;
                    idx    = IDX_W'(st_q.level - 2'd2);
                end
            end
        end
        ticks_o = ticks_of(codes_i[idx]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= '{dir: DIR_DOWN, busy: 1'b0, level: '0};
            done_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= done_d;
        end
    end

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_mask
        assign mask_o[g] = (st_q.level > LVL_W'(g));
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pseq_pkg::*;
#(
    parameter int HALF_MS_CYCLES = 50000,
    parameter int FILT_HALF_MS   = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          master_en_i,
    input  logic [NUM_RAILS-1:0]          ext_en_i,
    input  logic                          cfg_wr_i,
    input  logic [NUM_RAILS-1:0]          cfg_rail_en_i,
    input  logic [NUM_RAILS*CODE_W-1:0]   cfg_dly_i,
    output logic [NUM_RAILS-1:0]          rail_on_o,
    output logic                          seq_busy_o,
    output logic                          seq_done_o
);
    localparam int FILT_CYCLES = FILT_HALF_MS * HALF_MS_CYCLES;

    rail_cfg_t            cfg_q;
    logic [NUM_RAILS-1:0] ext_q1, ext_q2;
    logic [NUM_RAILS-1:0] seq_mask;
    logic                 m_rise, m_fall;
    logic                 t_load, t_stop, t_expire;
    tick_cnt_t            t_ticks;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q.en  <= '1;
            cfg_q.dly <= DEFAULT_CODES;
        end else if (cfg_wr_i) begin
            cfg_q.en  <= cfg_rail_en_i;
            cfg_q.dly <= cfg_dly_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ext_q1 <= '0;
            ext_q2 <= '0;
        end else begin
            ext_q1 <= ext_en_i;
            ext_q2 <= ext_q1;
        end
    end

    pseq_deglitch #(.STABLE_CYCLES(FILT_CYCLES)) u_filt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .raw_i  (master_en_i),
        .rise_o (m_rise),
        .fall_o (m_fall)
    );

    pseq_walker u_walk (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rise_i   (m_rise),
        .fall_i   (m_fall),
        .expire_i (t_expire),
        .codes_i  (cfg_q.dly),
        .load_o   (t_load),
        .stop_o   (t_stop),
        .ticks_o  (t_ticks),
        .mask_o   (seq_mask),
        .busy_o   (seq_busy_o),
        .done_o   (seq_done_o)
    );

    pseq_step_timer #(.HALF_MS_CYCLES(HALF_MS_CYCLES)) u_tmr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (t_load),
        .stop_i   (t_stop),
        .ticks_i  (t_ticks),
        .expire_o (t_expire)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        always_ff @(posedge clk_i) begin
            if (rst_i) rail_on_o[g] <= 1'b0;
            else       rail_on_o[g] <= cfg_q.en[g] & (ext_q2[g] | seq_mask[g]);
        end
    end
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker
    import pseq_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_i,
    input logic [NUM_RAILS-1:0] rail_on_o,
    input logic [NUM_RAILS-1:0] en_q,
    input logic [NUM_RAILS-1:0] seq_mask,
    input logic                 seq_busy_o,
    input logic                 seq_done_o
);
    // R4 R6: sequenced rails always form a contiguous run from rail 0
    a_r4_mask_prefix: assert property (@(posedge clk_i) disable iff (rst_i)
        ((seq_mask & (seq_mask + 1'b1)) == '0));

    // R4 R6: at most one rail changes per step
    a_r6_one_step: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(seq_mask ^ $past(seq_mask)) <= 1));

    // R8: sequenced enables move only while a walk is in progress
    a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seq_busy_o) |=> $stable(seq_mask));

    // R8: done is a single-cycle pulse, never together with busy
    a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        seq_done_o |-> (!seq_busy_o));
    a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        seq_done_o |=> !seq_done_o);

    // R2: a rail with its enable bit clear is off on the next cycle
    a_r2_bit_gates: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_q != '1) |=> ((rail_on_o & ~$past(en_q)) == '0));
endmodule

bind pwr_seq_ctrl pseq_checker chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rail_on_o  (rail_on_o),
    .en_q       (cfg_q.en),
    .seq_mask   (seq_mask),
    .seq_busy_o (seq_busy_o),
    .seq_done_o (seq_done_o)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
    localparam int HALF = 10;
    localparam int FILT = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master = 1'b0;
    logic [3:0]  ext = '0;
    logic        wr = 1'b0;
    logic [3:0]  wen = '0;
    logic [11:0] wdly = '0;
    logic [3:0]  rail;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    int t_on[4];
    int t_off[4];
    logic [3:0] prev = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwr_seq_ctrl #(.HALF_MS_CYCLES(HALF), .FILT_HALF_MS(2)) dut_i (
        .clk_i(clk), .rst_i(rst), .master_en_i(master), .ext_en_i(ext),
        .cfg_wr_i(wr), .cfg_rail_en_i(wen), .cfg_dly_i(wdly),
        .rail_on_o(rail), .seq_busy_o(busy), .seq_done_o(done)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (done) done_cnt <= done_cnt + 1;
        for (int i = 0; i < 4; i++) begin
            if (rail[i] && !prev[i]) t_on[i] <= cyc;
            if (!rail[i] && prev[i]) t_off[i] <= cyc;
        end
        prev <= rail;
    end

    function automatic int ticks(input logic [2:0] c);
        case (c)
            3'd0: return 2;
            3'd1: return 3;
            3'd2: return 4;
            3'd3: return 6;
            3'd4: return 12;
            default: return 22;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_times();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin t_on[i] = -1; t_off[i] = -1; end
    endtask

    task automatic cfg_write(input logic [3:0] e, input logic [11:0] d);
        @(negedge clk);
        wr = 1'b1; wen = e; wdly = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic run_up(input logic [11:0] d, input string tag);
        int t0, d0, dc;
        clr_times();
        dc = done_cnt;
        @(negedge clk);
        master = 1'b1; t0 = cyc;
        repeat (FILT + 4 * 22 * HALF + 40) @(negedge clk);
        d0 = t_on[0] - t0;
        chk(d0 >= ticks(d[2:0]) * HALF + FILT && d0 <= ticks(d[2:0]) * HALF + FILT + 10,
            {tag, " R3 R4 first step"}, d0, ticks(d[2:0]) * HALF + FILT);
        for (int k = 1; k < 4; k++)
            chk(t_on[k] - t_on[k-1] == ticks(d[3*k +: 3]) * HALF,
                {tag, " R4 R5 on interval"}, t_on[k] - t_on[k-1], ticks(d[3*k +: 3]) * HALF);
        chk(rail == 4'hF, {tag, " R4 all on"}, rail, 15);
        chk(done_cnt - dc == 1, {tag, " R8 done count up"}, done_cnt - dc, 1);
    endtask

    task automatic run_down(input logic [11:0] d, input string tag);
        int dc;
        clr_times();
        dc = done_cnt;
        @(negedge clk);
        master = 1'b0;
        repeat (FILT + 20) @(negedge clk);
        chk(busy == 1'b1, {tag, " R8 busy mid walk"}, busy, 1);
        repeat (4 * 22 * HALF + 20) @(negedge clk);
        for (int k = 0; k < 3; k++)
            chk(t_off[k] - t_off[k+1] == ticks(d[3*k +: 3]) * HALF,
                {tag, " R6 off interval"}, t_off[k] - t_off[k+1], ticks(d[3*k +: 3]) * HALF);
        chk(rail == 4'h0, {tag, " R6 all off"}, rail, 0);
        chk(busy == 1'b0, {tag, " R8 busy idle"}, busy, 0);
        chk(done_cnt - dc == 1, {tag, " R8 done count down"}, done_cnt - dc, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rail == 4'h0, "R1 reset rails", rail, 0);
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);

        // R1 default delay codes 1,2,3,4
        run_up(12'b100_011_010_001, "R1 default");

        // R7 external pins ignored once fully on
        for (int n = 0; n < 20; n++) begin
            ext = 4'($urandom);
            repeat (5) @(negedge clk);
            chk(rail == 4'hF, "R7 ext ignored", rail, 15);
        end
        ext = '0;
        run_down(12'b100_011_010_001, "R1 default");

        // R3 glitches shorter than the filter time are ignored
        for (int w = 1; w < FILT; w += 6) begin
            @(negedge clk); master = 1'b1;
            repeat (w) @(negedge clk);
            master = 1'b0;
            repeat (300) @(negedge clk);
            chk(rail == 4'h0 && busy == 1'b0, "R3 glitch ignored", rail, 0);
        end

        // R2 R10 direct path while idle, with random enable bits
        for (int n = 0; n < 6; n++) begin
            logic [3:0] e, p;
            e = 4'($urandom); p = 4'($urandom);
            cfg_write(e, 12'h000);
            ext = p;
            repeat (5) @(negedge clk);
            chk(rail == (e & p), "R2 R10 rail equation", rail, e & p);
        end
        ext = '0;

        // R4 R5 R6 random delay codes including 5..7
        for (int n = 0; n < 5; n++) begin
            logic [11:0] d;
            d = 12'($urandom);
            cfg_write(4'hF, d);
            run_up(d, "R5 random");
            run_down(d, "R5 random");
        end

        // R9 reversal mid power-on
        cfg_write(4'hF, 12'b011_011_011_011);
        clr_times();
        begin
            int dc;
            dc = done_cnt;
            @(negedge clk); master = 1'b1;
            while (!rail[1]) @(negedge clk);
            master = 1'b0;
            repeat (400) @(negedge clk);
            chk(t_on[2] == -1 && t_on[3] == -1, "R9 unreached rails stay off", t_on[2], -1);
            chk(t_off[0] - t_off[1] == ticks(3'd3) * HALF, "R9 reverse interval",
                t_off[0] - t_off[1], ticks(3'd3) * HALF);
            chk(rail == 4'h0, "R9 ends off", rail, 0);
            chk(done_cnt - dc == 1, "R9 R8 single done", done_cnt - dc, 1);
        end

        // R10 enable bit clear blocks the sequence for that rail
        cfg_write(4'b1011, 12'b000_000_000_000);
        run_up_partial();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_up_partial();
        @(negedge clk); master = 1'b1;
        repeat (FILT + 200) @(negedge clk);
        chk(rail == 4'b1011, "R10 R2 gated rail", rail, 11);
        ext = 4'b0100;
        repeat (5) @(negedge clk);
        chk(rail == 4'b1011, "R2 gated ext", rail, 11);
        ext = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule